// File: doc/BRIEF.md
# SM3 Message Schedule Expansion Unit

This block produces four new 32-bit words of the SM3 message schedule per pass. The expansion is split into two operations that a caller issues in turn. The pre step folds XOR and rotate terms of earlier schedule words and runs each lane through the P1 permutation. The finish step combines those intermediate values with further earlier words. Its top lane is then corrected with a term built from the first new word of the same pass. An operation-select bit chooses which step a transaction performs. All three 128-bit operands are packed as four 32-bit dwords, with dword j occupying bits [32j+31:32j].

A valid/ready handshake surrounds a combinational datapath with one result register. A transaction is taken when `inValid` and `inReady` are both high. The result is then held with `outValid` high until the consumer raises `outReady`. While a result is held, the unit refuses new input.

Top module: `sm3_wexp`

## Requirements
- R1: While `rstN` is low at a clock edge, `outValid` is 0 after that edge; after reset `inReady` is 1.
- R2: With `opSel`=0 (pre step), for lanes j=0..2 the intermediate value is srcA[j] ^ srcC[j] ^ rotl(srcB[j],15).
- R3: With `opSel`=0, lane 3's intermediate value is srcA[3] ^ srcC[3] with no rotate term, and srcB dword 3 has no effect on the result.
- R4: With `opSel`=0, result dword j equals P1 of lane j's intermediate value, where P1(x) = x ^ rotl(x,15) ^ rotl(x,23).
- R5: With `opSel`=1 (finish step), for j=0..2 result dword j equals rotl(srcB[j],7) ^ srcC[j] ^ srcA[j].
- R6: With `opSel`=1, result dword 3 equals v ^ rotl(n,6) ^ rotl(n,15) ^ rotl(n,30), where v = rotl(srcB[3],7) ^ srcC[3] ^ srcA[3] and n is result dword 0.
- R7: A transaction is captured only at an edge where `inValid` and `inReady` are both high, and `outValid` is 1 after that edge.
- R8: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1, `result` stays unchanged, `inReady` is 0, and input presented then is ignored.
- R9: At an edge with `outValid` and `outReady` both high, the result is released: `outValid` is 0 and `inReady` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request carries a valid operation |
| inReady | output | 1 | Unit can accept a request |
| opSel | input | 1 | 0 = pre step, 1 = finish step |
| srcA | input | 128 | Operand A, four dwords |
| srcB | input | 128 | Operand B, four dwords |
| srcC | input | 128 | Operand C, four dwords |
| outValid | output | 1 | Result register holds an unconsumed result |
| outReady | input | 1 | Consumer takes the result |
| result | output | 128 | Four new schedule dwords |

## Verification
The bound checker watches the handshake on every cycle. It checks that reset clears the output flag, that a handshake always loads a result, that a held result neither changes nor drops, and that a release frees the unit on the next edge. The arithmetic of both steps is shown only by the bench's directed scenarios. These cover a single-bit input that exposes the P1 rotations, the top-lane patch driven by dword 0, the unused operand B dword in the pre step, and mixed patterns compared against a model written from the formulas.

// File: rtl/sm3_wexp_pkg.sv
package sm3_wexp_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int VEC_W  = WORD_W * LANES;

  // rotate amounts of the two steps
  localparam int PRE_ROT   = 15;
  localparam int P1_ROT_LO = 15;
  localparam int P1_ROT_HI = 23;
  localparam int FIN_ROT   = 7;
  localparam int FIX_ROT0  = 6;
  localparam int FIX_ROT1  = 15;
  localparam int FIX_ROT2  = 30;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic load;    // capture the datapath result
    logic finish;  // select the finish step
  } ctrlStrobes_t;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    int unsigned k;
    k = n % WORD_W;
    if (k == 0) return x;
    return (x << k) | (x >> (WORD_W - k));
  endfunction

  function automatic word_t permP1(input word_t x);
    return x ^ rotl(x, P1_ROT_LO) ^ rotl(x, P1_ROT_HI);
  endfunction
endpackage

// File: rtl/sm3_wexp_ctrl.sv
module sm3_wexp_ctrl
  import sm3_wexp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  input  logic         opSel,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobe
);
  logic heldQ;
  logic fire;

  assign inReady       = !heldQ;
  assign fire          = inValid && inReady;
  assign strobe.load   = fire;
  assign strobe.finish = opSel;
  assign outValid      = heldQ;

  always_ff @(posedge clk) begin
    if (!rstN)         heldQ <= 1'b0;
    else if (fire)     heldQ <= 1'b1;
    else if (outReady) heldQ <= 1'b0;
  end
endmodule

// File: rtl/sm3_wexp_datapath.sv
module sm3_wexp_datapath
  import sm3_wexp_pkg::*;
(
  input  logic             clk,
  input  ctrlStrobes_t     strobe,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] srcC,
  output logic [VEC_W-1:0] result
);
  localparam int TOP = LANES - 1;

  word_t aW [LANES];
  word_t bW [LANES];
  word_t cW [LANES];
  word_t preTmp [LANES];
  word_t finBase [LANES];
  logic [VEC_W-1:0] preVec;
  logic [VEC_W-1:0] finVec;
  logic [VEC_W-1:0] resultQ;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign aW[j] = srcA[j*WORD_W +: WORD_W];
    assign bW[j] = srcB[j*WORD_W +: WORD_W];
    assign cW[j] = srcC[j*WORD_W +: WORD_W];

    if (j < TOP) begin : g_preRot
      assign preTmp[j] = aW[j] ^ cW[j] ^ rotl(bW[j], PRE_ROT);
    end else begin : g_preTop
      assign preTmp[j] = aW[j] ^ cW[j];
    end
    assign preVec[j*WORD_W +: WORD_W] = permP1(preTmp[j]);

    assign finBase[j] = rotl(bW[j], FIN_ROT) ^ cW[j] ^ aW[j];
    if (j == TOP) begin : g_finFix
      assign finVec[j*WORD_W +: WORD_W] = finBase[j]
        ^ rotl(finBase[0], FIX_ROT0) ^ rotl(finBase[0], FIX_ROT1)
        ^ rotl(finBase[0], FIX_ROT2);
    end else begin : g_finPlain
      assign finVec[j*WORD_W +: WORD_W] = finBase[j];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.load) resultQ <= strobe.finish ? finVec : preVec;
  end

  assign result = resultQ;
endmodule

// File: rtl/sm3_wexp.sv
module sm3_wexp
  import sm3_wexp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic             opSel,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] srcC,
  output logic             outValid,
  input  logic             outReady,
  output logic [VEC_W-1:0] result
);
  ctrlStrobes_t strobe;

  sm3_wexp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .opSel(opSel), .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  sm3_wexp_datapath u_dp (
    .clk(clk), .strobe(strobe), .srcA(srcA), .srcB(srcB), .srcC(srcC),
    .result(result)
  );
endmodule

// File: rtl/sm3_wexp_chk.sv
module sm3_wexp_chk
  import sm3_wexp_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [VEC_W-1:0] result
);
  assert_reset_R1: assert property (@(posedge clk) !rstN |=> !outValid);

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  assert_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(result));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady |=> !outValid && inReady);
endmodule

bind sm3_wexp sm3_wexp_chk u_chk (.*);

// File: tb/tb_sm3_wexp.sv
module tb_sm3_wexp;
  logic clk = 1'b0;
  logic rstN, inValid, inReady, opSel, outValid, outReady;
  logic [127:0] srcA, srcB, srcC, result;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sm3_wexp dut (.*);

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    int k = n % 32;
    if (k == 0) return x;
    return (x << k) | (x >> (32 - k));
  endfunction

  function automatic logic [127:0] modelPre(input logic [127:0] a, b, c);
    logic [127:0] r;
    for (int j = 0; j < 4; j++) begin
      logic [31:0] t;
      t = a[32*j +: 32] ^ c[32*j +: 32];
      if (j < 3) t = t ^ rl(b[32*j +: 32], 15);
      r[32*j +: 32] = t ^ rl(t, 15) ^ rl(t, 23);
    end
    return r;
  endfunction

  function automatic logic [127:0] modelFin(input logic [127:0] a, b, c);
    logic [127:0] r;
    for (int j = 0; j < 4; j++)
      r[32*j +: 32] = rl(b[32*j +: 32], 7) ^ c[32*j +: 32] ^ a[32*j +: 32];
    r[127:96] = r[127:96] ^ rl(r[31:0], 6) ^ rl(r[31:0], 15) ^ rl(r[31:0], 30);
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one operation, check the captured result, hold it while offering
  // new input, then release it.
  task automatic runOp(input string req, input logic op,
                       input logic [127:0] a, b, c, exp);
    @(negedge clk);
    inValid = 1'b1; opSel = op; srcA = a; srcB = b; srcC = c;
    @(negedge clk);
    inValid = 1'b0;
    check("R7", {127'd0, outValid}, 128'd1);
    check(req, result, exp);
    // held: new request must be ignored (R8)
    inValid = 1'b1; opSel = ~op; srcA = ~a; srcB = b ^ 128'h5; srcC = ~c;
    @(negedge clk);
    check("R8", {126'd0, outValid, inReady}, 128'd2);
    check("R8", result, exp);
    @(negedge clk);
    inValid = 1'b0;
    check("R8", result, exp);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check("R9", {126'd0, outValid, inReady}, 128'd1);
  endtask

  task automatic testReset();
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b0; opSel = 1'b0;
    srcA = '0; srcB = '0; srcC = '0;
    repeat (3) @(negedge clk);
    check("R1", {126'd0, outValid, inReady}, 128'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {126'd0, outValid, inReady}, 128'd1);
  endtask

  task automatic testP1Bit();
    // single set bit in lane 0: P1(1) = 1 ^ 1<<15 ^ 1<<23
    runOp("R4", 1'b0, 128'd1, 128'd0, 128'd0, {96'd0, 32'h0080_8001});
  endtask

  task automatic testPreRotate();
    // B lane1 bit0 alone -> tmp1 = 1<<15; P1 gives bits 15,30,6
    runOp("R2", 1'b0, 128'd0, {64'd0, 32'h1, 32'd0}, 128'd0,
          {64'd0, 32'h4000_8040, 32'd0});
  endtask

  task automatic testPreTopLane();
    logic [127:0] a = {32'h1234_5678, 96'd0};
    logic [127:0] c = {32'h0F0F_0000, 96'd0};
    logic [127:0] e = modelPre(a, 128'd0, c);
    runOp("R3", 1'b0, a, 128'd0, c, e);
    runOp("R3", 1'b0, a, {32'hFFFF_FFFF, 96'd0}, c, e);  // B dword3 ignored
  endtask

  task automatic testFinishPatch();
    // A lane0 = 1 -> W16 = 1; top lane = rotl(1,6)^rotl(1,15)^rotl(1,30)
    runOp("R6", 1'b1, 128'd1, 128'd0, 128'd0,
          {32'h4000_8040, 64'd0, 32'h1});
    runOp("R5", 1'b1, 128'd0, {64'd0, 32'h8000_0000, 32'd0}, 128'd0,
          {64'd0, 32'h40, 32'd0});
  endtask

  task automatic testMixed();
    logic [127:0] a = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    logic [127:0] b = 128'hDEAD_BEEF_CAFE_F00D_A5A5_5A5A_0F1E_2D3C;
    logic [127:0] c = 128'h1357_9BDF_2468_ACE0_FFFF_0000_8000_0001;
    runOp("R2", 1'b0, a, b, c, modelPre(a, b, c));
    runOp("R5", 1'b1, a, b, c, modelFin(a, b, c));
    runOp("R6", 1'b1, b, c, a, modelFin(b, c, a));
    runOp("R4", 1'b0, '1, '0, '0, modelPre('1, '0, '0));
    runOp("R5", 1'b1, '0, '0, '0, 128'd0);
  endtask

  initial begin
    testReset();
    testP1Bit();
    testPreRotate();
    testPreTopLane();
    testFinishPatch();
    testMixed();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule